// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture

This block is a 16-bit up-counter that runs continuously from a divided system clock. The divide ratio is a power of two, with the exponent set in software. Four compare channels watch the count. Each one raises a flag when the count equals its value. Channel 0 can also fold the count back to zero, which turns the free-running timer into a period timer. Compare channels are grouped in pairs: the even member of a pair drives a waveform pin high and the odd member drives it low. This gives a pulse whose edges are placed independently.

Four capture channels take asynchronous pins. Each pin is synchronized, and the chosen edge copies the running count into that channel's capture register. Every event source has a sticky flag and an enable bit. The interrupt line is the OR of the enabled flags.

Software reaches the block through a flat register port. Writes take effect on the clock edge that samples them, and reads return the addressed register combinationally. There is no stream data path and no back-pressure. Register map, word addresses:

| Address | Register |
|---|---|
| 0 | Control: bits 2:0 are the prescale exponent n, bit 3 enables clear on compare 0, bit 4 restarts the timer (write-only, reads 0). |
| 1 | Capture modes: 2 bits per channel. |
| 2 | Interrupt enables. |
| 3 | Flags. |
| 4 | Count, read only. |
| 8–11 | Compare 0–3. |
| 12–15 | Capture 0–3, read only. |

The enables and the flags share one layout: bit 0 is overflow, bits 1–4 are compare 0–3 and bits 5–8 are capture 0–3.

Top module: `frt_cc_unit`

## Requirements
- R1: While reset is held, the count, the flags, the waveform pins and irq all read 0.
- R2: The count advances by exactly one per step. It holds between steps. After a restart with exponent n (control bits 2:0), the count equals floor(k / 2^n) after k clock edges.
- R3: A step taken from 0xFFFF to 0 sets flag bit 0.
- R4: A step taken while the count equals compare i sets flag bit 1+i. The next value of the count is visible on the edge that sets the flag.
- R5: With control bit 3 set, a step taken while the count equals compare 0 loads 0 instead of incrementing. This wrap does not set flag bit 0.
- R6: A match on compare 2j drives wave_out[j] to 1, and a match on compare 2j+1 drives it to 0. When both match on the same step, the 0 wins.
- R7: The mode bits 2i+1:2i for capture channel i are 00 off, 01 rising, 10 falling and 11 both edges. Suppose cap_pin changes before clock edge E1. The capture register then holds the count present after E2, and it is visible after E3.
- R8: A capture sets flag bit 5+i. An edge that the mode does not select changes neither the capture register nor the flag.
- R9: Writing the flags register clears the bits written as 1 and leaves the bits written as 0. When a set and a clear fall on the same edge, the set wins.
- R10: irq is 1 exactly when some flag bit and its enable bit are both 1.
- R11: A write with control bit 4 set zeroes the count, the prescaler phase and every waveform pin on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Word address for both read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cap_pin | input | 4 | Asynchronous capture inputs |
| wave_out | output | 2 | Pair-driven waveform pins |
| irq | output | 1 | OR of the enabled flags |

## Verification
The assertions treat a register write as a single-cycle strobe. They treat a restart as overriding any step or clear in the same cycle, so each step property excludes the restart cycle. The capture properties assume that each pin level lasts at least three clocks, so that the synchronizer output shows every transition. The stimulus holds each capture pin level for many clocks, issues every write as one strobed cycle between clock edges, and starts each timing measurement from a restart so that the prescaler phase is known.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_mode_e;

  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_CAPMODE  = 1;
  localparam int unsigned REG_IEN      = 2;
  localparam int unsigned REG_IFLG     = 3;
  localparam int unsigned REG_COUNT    = 4;
  localparam int unsigned REG_CMP_BASE = 8;
endpackage

// File: rtl/frt_timebase.sv
module frt_timebase #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] scale,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             ovf_evt
);
  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  // Low n bits of the phase all ones marks the last cycle of a 2^n window.
  assign mask    = ~({DIV_W{1'b1}} << scale);
  assign tick    = (phase_q & mask) == mask;
  assign ovf_evt = tick && !clr_req && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase_q <= '0;
      cnt     <= '0;
    end else begin
      phase_q <= phase_q + DIV_W'(1);
      if (tick) begin
        cnt <= clr_req ? '0 : cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frt_cmp_pair.sv
module frt_cmp_pair #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_set,
  input  logic [CNT_W-1:0] cmp_clr,
  output logic [1:0]       hit,
  output logic             wave
);
  // Matches are qualified by the step strobe: one pulse per count value.
  assign hit[0] = tick && (cnt == cmp_set);
  assign hit[1] = tick && (cnt == cmp_clr);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      wave <= 1'b0;
    end else if (hit[1]) begin
      wave <= 1'b0;
    end else if (hit[0]) begin
      wave <= 1'b1;
    end
  end
endmodule

// File: rtl/frt_cap_chan.sv
module frt_cap_chan
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  cap_mode_e        mode,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt
);
  // sync_q[0..1] resynchronise, sync_q[2] holds the previous settled level.
  logic [2:0] sync_q;
  logic       rise, fall;

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    unique case (mode)
      CAP_RISE: cap_evt = rise;
      CAP_FALL: cap_evt = fall;
      CAP_BOTH: cap_evt = rise | fall;
      default:  cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cap_val <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin};
      if (cap_evt) begin
        cap_val <= cnt;
      end
    end
  end
endmodule

// File: rtl/frt_cc_unit.sv
module frt_cc_unit
  import frt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned N_CAP  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  input  logic [N_CAP-1:0]     cap_pin,
  output logic [N_CMP/2-1:0]   wave_out,
  output logic                 irq
);
  localparam int unsigned N_PAIR   = N_CMP / 2;
  localparam int unsigned FLAG_W   = 1 + N_CMP + N_CAP;
  localparam int unsigned CAP_BASE = REG_CMP_BASE + N_CMP;
  localparam int unsigned CLR_BIT  = PRE_W;
  localparam int unsigned RST_BIT  = PRE_W + 1;

  logic [PRE_W-1:0]   scale_q;
  logic               clr_en_q;
  logic [2*N_CAP-1:0] capmode_q;
  logic [FLAG_W-1:0]  ien_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [CNT_W-1:0]   cmp_val [N_CMP];
  logic [CNT_W-1:0]   cap_val [N_CAP];

  logic [CNT_W-1:0]   count_q;
  logic               tick;
  logic               ovf_evt;
  logic               restart;
  logic               clr_req;
  logic [N_CMP-1:0]   cmp_hit;
  logic [N_CAP-1:0]   cap_evt;
  logic               wr_ctrl, wr_flags;
  logic [FLAG_W-1:0]  set_vec, clr_vec;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
  assign wr_flags = reg_wr && (reg_addr == ADDR_W'(REG_IFLG));
  assign restart  = wr_ctrl && reg_wdata[RST_BIT];
  assign clr_req  = clr_en_q && cmp_hit[0];

  frt_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .scale   (scale_q),
    .clr_req (clr_req),
    .cnt     (count_q),
    .tick    (tick),
    .ovf_evt (ovf_evt)
  );

  for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
    frt_cmp_pair #(.CNT_W(CNT_W)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick),
      .cnt     (count_q),
      .cmp_set (cmp_val[2*j]),
      .cmp_clr (cmp_val[2*j+1]),
      .hit     (cmp_hit[2*j +: 2]),
      .wave    (wave_out[j])
    );
  end

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    frt_cap_chan #(.CNT_W(CNT_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (cap_pin[i]),
      .mode    (cap_mode_e'(capmode_q[2*i +: 2])),
      .cnt     (count_q),
      .cap_val (cap_val[i]),
      .cap_evt (cap_evt[i])
    );
  end

  // Flag layout: overflow, then compares, then captures.
  assign set_vec = {cap_evt, cmp_hit, ovf_evt};
  assign clr_vec = wr_flags ? reg_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q   <= '0;
      clr_en_q  <= 1'b0;
      capmode_q <= '0;
      ien_q     <= '0;
      flags_q   <= '0;
      for (int i = 0; i < N_CMP; i++) cmp_val[i] <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (wr_ctrl) begin
        scale_q  <= reg_wdata[PRE_W-1:0];
        clr_en_q <= reg_wdata[CLR_BIT];
      end
      if (reg_wr && reg_addr == ADDR_W'(REG_CAPMODE)) capmode_q <= reg_wdata[2*N_CAP-1:0];
      if (reg_wr && reg_addr == ADDR_W'(REG_IEN))     ien_q     <= reg_wdata[FLAG_W-1:0];
      for (int i = 0; i < N_CMP; i++) begin
        if (reg_wr && reg_addr == ADDR_W'(REG_CMP_BASE + i)) cmp_val[i] <= reg_wdata;
      end
    end
  end

  assign irq = |(flags_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(REG_CTRL))    reg_rdata[PRE_W:0]      = {clr_en_q, scale_q};
    if (reg_addr == ADDR_W'(REG_CAPMODE)) reg_rdata[2*N_CAP-1:0]  = capmode_q;
    if (reg_addr == ADDR_W'(REG_IEN))     reg_rdata[FLAG_W-1:0]   = ien_q;
    if (reg_addr == ADDR_W'(REG_IFLG))    reg_rdata[FLAG_W-1:0]   = flags_q;
    if (reg_addr == ADDR_W'(REG_COUNT))   reg_rdata               = count_q;
    for (int i = 0; i < N_CMP; i++) begin
      if (reg_addr == ADDR_W'(REG_CMP_BASE + i)) reg_rdata = cmp_val[i];
    end
    for (int i = 0; i < N_CAP; i++) begin
      if (reg_addr == ADDR_W'(CAP_BASE + i)) reg_rdata = cap_val[i];
    end
  end
endmodule

// File: rtl/frt_cc_chk.sv
module frt_cc_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned N_CAP  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    restart,
  input logic                    clr_en,
  input logic [CNT_W-1:0]        cnt,
  input logic [CNT_W-1:0]        cmp0,
  input logic [N_CMP-1:0]        cmp_hit,
  input logic [N_CAP+N_CMP:0]    flags,
  input logic [N_CMP/2-1:0]      wave_out,
  input logic                    clr_ovf_wr
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !(clr_en && cnt == cmp0)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && !(clr_en && cnt == cmp0) && cnt == {CNT_W{1'b1}}) |=> flags[0]);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && clr_en && cnt == cmp0) |=> (cnt == '0));

  // R9
  w1c_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf_wr && !(tick && cnt == {CNT_W{1'b1}})) |=> !flags[0]);

  // R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    // R4
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |=> flags[1+i]);
  end

  for (genvar j = 0; j < N_CMP/2; j++) begin : g_wave
    // R6
    wave_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wave_out[j]) |-> $past(cmp_hit[2*j]));
    // R6
    wave_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wave_out[j]) |-> ($past(cmp_hit[2*j+1]) || $past(restart)));
  end
endmodule

bind frt_cc_unit frt_cc_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP), .N_CAP(N_CAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .restart    (restart),
  .clr_en     (clr_en_q),
  .cnt        (count_q),
  .cmp0       (cmp_val[0]),
  .cmp_hit    (cmp_hit),
  .flags      (flags_q),
  .wave_out   (wave_out),
  .clr_ovf_wr (wr_flags && reg_wdata[0])
);

// File: tb/frt_cc_unit_bench.sv
`timescale 1ns/1ps
module frt_cc_unit_bench;
  localparam int A_CTRL = 0, A_MODE = 1, A_IEN = 2, A_FLG = 3, A_CNT = 4;
  localparam int A_CMP = 8, A_CAP = 12;
  localparam int RESTART = 16, CLRMATCH = 8;

  // {exponent n, edges k after restart, expected count}
  localparam int VEC [8][3] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 11, 2}, '{3, 40, 5},
    '{4, 17, 1},  '{5, 64, 2}, '{6, 127, 1}, '{7, 300, 2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cap_pin = '0;
  logic [1:0]  wave_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  frt_cc_unit u_frt_cc_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
    .wave_out(wave_out), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr  = 5'(a);
    reg_wdata = 16'(d);
    reg_wr    = 1'b1;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    reg_addr = 5'(a);
    #0.1;
    v = reg_rdata;
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_FLG, v);  chk("R1 flags", v, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 irq", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R11: prescaler table
    for (int t = 0; t < 8; t++) begin
      wr(A_CTRL, RESTART | VEC[t][0]);
      step(VEC[t][1]);
      rd(A_CNT, v);
      chk($sformatf("R2 n=%0d k=%0d", VEC[t][0], VEC[t][1]), v, VEC[t][2]);
    end

    // R4: compare 2 flag
    wr(A_CMP + 2, 5);
    wr(A_FLG, 16'h1FF);
    wr(A_CTRL, RESTART);
    step(5);
    rd(A_FLG, v);  chk("R4 no flag before match", v[3], 0);
    rd(A_CNT, v);  chk("R4 count at match", v, 5);
    step(1);
    rd(A_FLG, v);  chk("R4 flag on match step", v[3], 1);
    rd(A_CNT, v);  chk("R4 count after match", v, 6);

    // R10/R9: enables and write-one-to-clear
    chk("R10 irq masked", irq, 0);
    wr(A_IEN, 8);
    chk("R10 irq enabled", irq, 1);
    wr(A_FLG, 0);
    rd(A_FLG, v);  chk("R9 zero write keeps flag", v[3], 1);
    wr(A_FLG, 8);
    rd(A_FLG, v);  chk("R9 one write clears flag", v[3], 0);
    chk("R10 irq after clear", irq, 0);
    wr(A_IEN, 0);

    // R5: clear on compare 0
    wr(A_CMP, 5);
    wr(A_CTRL, RESTART | CLRMATCH);
    step(6);
    rd(A_CNT, v);  chk("R5 cleared on match", v, 0);
    step(5);
    rd(A_CNT, v);  chk("R5 second period", v, 5);
    step(1);
    rd(A_CNT, v);  chk("R5 cleared again", v, 0);

    // R6: pair waveform
    wr(A_CMP, 10);
    wr(A_CMP + 1, 20);
    wr(A_CTRL, RESTART);
    chk("R11 wave cleared by restart", wave_out[0], 0);
    step(10);  chk("R6 low before set match", wave_out[0], 0);
    step(1);   chk("R6 set by even channel", wave_out[0], 1);
    step(9);   chk("R6 held high", wave_out[0], 1);
    step(1);   chk("R6 cleared by odd channel", wave_out[0], 0);
    wr(A_CMP + 2, 7);
    wr(A_CMP + 3, 7);
    wr(A_CTRL, RESTART);
    step(9);   chk("R6 clear wins on tie", wave_out[1], 0);

    // R7/R8: capture modes ch0 rise, ch1 fall, ch2 both, ch3 off
    wr(A_MODE, 16'h39);
    wr(A_FLG, 16'h1FF);
    wr(A_CTRL, RESTART);
    step(4);
    cap_pin = 4'b1111;
    step(3);
    rd(A_CAP, v);      chk("R7 rising capture ch0", v, 6);
    rd(A_CAP + 1, v);  chk("R8 falling mode ignores rise", v, 0);
    rd(A_CAP + 2, v);  chk("R7 both mode rise", v, 6);
    rd(A_CAP + 3, v);  chk("R8 off mode ignores edge", v, 0);
    rd(A_FLG, v);      chk("R8 capture flags after rise", v[8:5], 4'b0101);
    wr(A_FLG, 16'h1FF);
    wr(A_CTRL, RESTART);
    step(9);
    cap_pin = 4'b0000;
    step(3);
    rd(A_CAP, v);      chk("R8 rising mode ignores fall", v, 6);
    rd(A_CAP + 1, v);  chk("R7 falling capture ch1", v, 11);
    rd(A_CAP + 2, v);  chk("R7 both mode fall", v, 11);
    rd(A_CAP + 3, v);  chk("R8 off mode stays", v, 0);
    rd(A_FLG, v);      chk("R8 capture flags after fall", v[8:5], 4'b0110);

    // R3: overflow wrap
    wr(A_FLG, 16'h1FF);
    wr(A_CTRL, RESTART);
    step(65535);
    rd(A_CNT, v);  chk("R3 count at top", v, 16'hFFFF);
    rd(A_FLG, v);  chk("R3 no overflow yet", v[0], 0);
    step(1);
    rd(A_CNT, v);  chk("R3 wrapped", v, 0);
    rd(A_FLG, v);  chk("R3 overflow flag", v[0], 1);

    // R5: clear-on-match wrap at top sets no overflow
    wr(A_CMP, 16'hFFFF);
    wr(A_FLG, 16'h1FF);
    wr(A_CTRL, RESTART | CLRMATCH);
    step(65536);
    rd(A_CNT, v);  chk("R5 wrapped by match", v, 0);
    rd(A_FLG, v);  chk("R5 no overflow on match wrap", v[0], 0);
    chk("R4 compare 0 flag at top", v[1], 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule